// File: doc/BRIEF.md
# Expansion Card Autoconfig Responder

This block is the plug-and-play configuration logic of a 64 KB expansion card on a 24-bit synchronous bus. After reset the card is unconfigured and answers at a fixed configuration window (address byte 0xE8 by default). Reads of the first 128 bytes of the card's local space return identification nibbles. Software then assigns a base address in two writes. A write at one offset loads the lower nibble of the base into a latch, and this write may be repeated. A second write at another offset supplies the upper nibble and commits the base.

Once the base is committed, the card leaves the configuration window and decodes only at the chosen 64 KB base. The rest of the card's decode logic receives a hit flag and the 16-bit local offset. The offset is decoded the same way before and after configuration, so the local register map is usable at both places. A shut-up write puts the card to sleep until reset. Both the commit and the shut-up raise a config-out signal for the next board in the chain.

Top module: `acfg_responder`

## Requirements
- R1: After reset, cfg_done, shut_up and cfg_out are 0, base_addr is 0x00, bus_rdata is 0xFF, and the base-nibble latch holds 0.
- R2: While unconfigured and not shut up, card_hit is 1 exactly when bus_addr[23:16] equals the window byte (default 0xE8). local_off always equals bus_addr[15:0].
- R3: A read that hits at an even local offset below 0x80 returns the identification nibble in bus_rdata[7:4], with bus_rdata[3:0] = 0, on the clock after the read. Any other read, and any cycle with no read, gives 0xFF on that clock.
- R4: The identification bytes are laid out as follows. Byte k is served at offset 4k (upper nibble) and at offset 4k+2 (lower nibble). Byte 0 is the board type 0xD1 (expansion card, 64 KB, ROM vector valid, no free-memory add, not chained) and is returned as stored. All other bytes are returned inverted. Byte 1 is the product. Byte 2 is the flags 0x00 (no space preference, shut-up supported). Bytes 4-5 are the manufacturer 0x1212. Bytes 6-9 are the serial number 0. Bytes 10-11 are the ROM vector 0x1000. Every other byte is 0.
- R5: A write at offset 0x4A while unconfigured loads bus_wdata[7:4] into the base-nibble latch. Each further 0x4A write overwrites it. No 0x4A write relocates the card.
- R6: A write at offset 0x48 while unconfigured sets base_addr to {bus_wdata[7:4], latch} and sets cfg_done and cfg_out from the next clock.
- R7: After configuration, card_hit is 1 exactly when bus_addr[23:16] equals base_addr. The configuration window no longer hits, and identification reads work at the new base.
- R8: A 0x48 write with no 0x4A write since reset uses a latch value of 0.
- R9: Once configured, writes at 0x48, 0x4A and 0x4C change neither base_addr nor the state.
- R10: A write at offset 0x4C while unconfigured sets shut_up and cfg_out. Until reset, card_hit stays 0, bus_rdata stays 0xFF, and later configuration writes have no effect (cfg_done stays 0 and base_addr stays 0x00).
- R11: The product byte is 0 when the parameter EXTENDED is 0 and 42 (0x2A) when EXTENDED is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Write data; configuration writes use bits 7:4 |
| bus_rdata | output | 8 | Registered read data, 0xFF when not driven |
| card_hit | output | 1 | Access falls in the card's current 64 KB space |
| local_off | output | 16 | Offset within the card space |
| cfg_done | output | 1 | Base committed |
| base_addr | output | 8 | Committed base (address bits 23:16) |
| shut_up | output | 1 | Card has been shut up |
| cfg_out | output | 1 | Configuration finished or skipped, for the next board |

## Verification
A wrong latch value first shows when the commit write lands. base_addr is then off in its low nibble on the next clock, and card_hit follows the wrong address byte from that point on. A lost or early configured flag is visible within one access, because card_hit answers at the wrong window. A wrong nibble selection or a missed inversion shows in bus_rdata one clock after the identification read. A sticky flag that clears by mistake shows as card_hit returning on the very next access.

// File: rtl/acfg_pkg.sv
package acfg_pkg;

  localparam logic [7:0]  TYPE_CODE  = 8'hD1;
  localparam logic [7:0]  FLAG_CODE  = 8'h00;
  localparam logic [15:0] MAKER_CODE = 16'h1212;
  localparam logic [31:0] SERIAL_NUM = 32'h0000_0000;
  localparam logic [15:0] BOOT_VEC   = 16'h1000;
  localparam logic [7:0]  PROD_BASE  = 8'd0;
  localparam logic [7:0]  PROD_EXT   = 8'd42;

  localparam logic [15:0] OFF_NIB_LO = 16'h004A;
  localparam logic [15:0] OFF_COMMIT = 16'h0048;
  localparam logic [15:0] OFF_SLEEP  = 16'h004C;
  localparam logic [15:0] ID_SPAN    = 16'h0080;

  typedef enum logic [1:0] {
    CW_NONE   = 2'd0,
    CW_LATCH  = 2'd1,
    CW_COMMIT = 2'd2,
    CW_SLEEP  = 2'd3
  } cfg_wr_e;

  // Identification byte k (served at offsets 4k and 4k+2).
  function automatic logic [7:0] id_byte(input logic [4:0] k, input logic [7:0] prod);
    logic [7:0] b;
    case (k)
      5'd0:    b = TYPE_CODE;
      5'd1:    b = prod;
      5'd2:    b = FLAG_CODE;
      5'd4:    b = MAKER_CODE[15:8];
      5'd5:    b = MAKER_CODE[7:0];
      5'd6:    b = SERIAL_NUM[31:24];
      5'd7:    b = SERIAL_NUM[23:16];
      5'd8:    b = SERIAL_NUM[15:8];
      5'd9:    b = SERIAL_NUM[7:0];
      5'd10:   b = BOOT_VEC[15:8];
      5'd11:   b = BOOT_VEC[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  // Nibble slot s = offset[6:1]; all but the type byte go out inverted.
  function automatic logic [3:0] id_nibble(input logic [5:0] s, input logic [7:0] prod);
    logic [7:0] b;
    logic [3:0] n;
    b = id_byte(s[5:1], prod);
    n = s[0] ? b[3:0] : b[7:4];
    return (s[5:1] == 5'd0) ? n : ~n;
  endfunction

endpackage

// File: rtl/acfg_decode.sv
module acfg_decode
  import acfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned LOCAL_W = 16,
  parameter logic [ADDR_W-LOCAL_W-1:0] WINDOW = 8'hE8
) (
  input  logic                      valid,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      cfg_q,
  input  logic                      shut_q,
  input  logic [ADDR_W-LOCAL_W-1:0] base_q,
  output logic                      hit,
  output logic [LOCAL_W-1:0]        off,
  output cfg_wr_e                   cfg_wr,
  output logic                      id_rd,
  output logic [5:0]                id_slot
);
  localparam int unsigned WIN_W = ADDR_W - LOCAL_W;

  logic [WIN_W-1:0] page;
  logic             wr_ok;

  assign page    = addr[ADDR_W-1:LOCAL_W];
  assign off     = addr[LOCAL_W-1:0];
  assign hit     = !shut_q && (cfg_q ? (page == base_q) : (page == WINDOW));
  assign wr_ok   = valid && we && hit && !cfg_q;
  assign id_rd   = valid && !we && hit && (off < LOCAL_W'(ID_SPAN)) && !off[0];
  assign id_slot = off[6:1];

  always_comb begin
    cfg_wr = CW_NONE;
    if (wr_ok) begin
      if (off == LOCAL_W'(OFF_NIB_LO))      cfg_wr = CW_LATCH;
      else if (off == LOCAL_W'(OFF_COMMIT)) cfg_wr = CW_COMMIT;
      else if (off == LOCAL_W'(OFF_SLEEP))  cfg_wr = CW_SLEEP;
    end
  end

endmodule

// File: rtl/acfg_state.sv
module acfg_state
  import acfg_pkg::*;
#(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_wr_e          cfg_wr,
  input  logic [3:0]       wnib,
  output logic             cfg_q,
  output logic             shut_q,
  output logic [WIN_W-1:0] base_q
);
  localparam int unsigned LAT_W = WIN_W / 2;

  logic [LAT_W-1:0] lat_q;
  logic             ev_latch;
  logic             ev_commit;
  logic             ev_sleep;

  assign ev_latch  = (cfg_wr == CW_LATCH);
  assign ev_commit = (cfg_wr == CW_COMMIT);
  assign ev_sleep  = (cfg_wr == CW_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      base_q <= '0;
      cfg_q  <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      if (ev_latch)  lat_q <= LAT_W'(wnib);
      if (ev_commit) begin
        base_q <= {LAT_W'(wnib), lat_q};
        cfg_q  <= 1'b1;
      end
      if (ev_sleep)  shut_q <= 1'b1;
    end
  end

  // R6
  commit_sets_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> cfg_q);

  // R5
  latch_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch |=> (!cfg_q && $stable(base_q)));

  // R9
  base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q |=> (cfg_q && $stable(base_q)));

  // R10
  shut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_q |=> (shut_q && !cfg_q));

endmodule

// File: rtl/acfg_idrom.sv
module acfg_idrom
  import acfg_pkg::*;
#(
  parameter logic [7:0] PRODUCT = 8'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_rd,
  input  logic [5:0] id_slot,
  output logic [7:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'hFF;
    else if (id_rd) rdata <= {id_nibble(id_slot, PRODUCT), 4'h0};
    else            rdata <= 8'hFF;
  end

  // R3
  low_nib_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |=> (rdata[3:0] == 4'h0));

endmodule

// File: rtl/acfg_responder.sv
module acfg_responder
  import acfg_pkg::*;
#(
  parameter bit          EXTENDED = 1'b0,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned LOCAL_W  = 16,
  parameter logic [7:0]  WINDOW   = 8'hE8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               card_hit,
  output logic [LOCAL_W-1:0] local_off,
  output logic               cfg_done,
  output logic [7:0]         base_addr,
  output logic               shut_up,
  output logic               cfg_out
);
  localparam int unsigned WIN_W   = ADDR_W - LOCAL_W;
  localparam logic [7:0]  PRODUCT = EXTENDED ? PROD_EXT : PROD_BASE;

  logic             cfg_q;
  logic             shut_q;
  logic [WIN_W-1:0] base_q;
  cfg_wr_e          cfg_wr;
  logic             id_rd;
  logic [5:0]       id_slot;
  logic             unused_low_data;

  assign unused_low_data = ^bus_wdata[3:0];

  acfg_decode #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W), .WINDOW(WIN_W'(WINDOW))) u_decode (
    .valid   (bus_valid),
    .we      (bus_we),
    .addr    (bus_addr),
    .cfg_q   (cfg_q),
    .shut_q  (shut_q),
    .base_q  (base_q),
    .hit     (card_hit),
    .off     (local_off),
    .cfg_wr  (cfg_wr),
    .id_rd   (id_rd),
    .id_slot (id_slot)
  );

  acfg_state #(.WIN_W(WIN_W)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_wr (cfg_wr),
    .wnib   (bus_wdata[7:4]),
    .cfg_q  (cfg_q),
    .shut_q (shut_q),
    .base_q (base_q)
  );

  acfg_idrom #(.PRODUCT(PRODUCT)) u_idrom (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_rd   (id_rd),
    .id_slot (id_slot),
    .rdata   (bus_rdata)
  );

  assign cfg_done  = cfg_q;
  assign base_addr = 8'(base_q);
  assign shut_up   = shut_q;
  assign cfg_out   = cfg_q | shut_q;

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_up |=> (bus_rdata == 8'hFF));

  // R7
  moved_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && card_hit) |-> (bus_addr[ADDR_W-1:LOCAL_W] == base_q));

endmodule

// File: tb/acfg_responder_bench.sv
module acfg_responder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, x_rdata;
  logic        card_hit, x_hit;
  logic [15:0] local_off, x_off;
  logic        cfg_done, x_done;
  logic [7:0]  base_addr, x_base;
  logic        shut_up, x_shut;
  logic        cfg_out, x_out;

  int total = 0;
  int bad = 0;
  logic        last_hit;
  logic [15:0] last_off;
  logic [7:0]  last_rd, last_xrd;

  always #4 clk = ~clk;

  acfg_responder u_acfg_responder (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .card_hit(card_hit), .local_off(local_off), .cfg_done(cfg_done),
    .base_addr(base_addr), .shut_up(shut_up), .cfg_out(cfg_out));

  acfg_responder #(.EXTENDED(1'b1)) u_ext (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(x_rdata),
    .card_hit(x_hit), .local_off(x_off), .cfg_done(x_done),
    .base_addr(x_base), .shut_up(x_shut), .cfg_out(x_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h want %0h", req, act, exp);
    end
  endtask

  // Expected read byte per R3/R4 written from the requirement text.
  function automatic logic [7:0] want_rd(input logic [15:0] off, input logic [7:0] prod);
    logic [7:0] raw;
    logic [3:0] nib;
    int k;
    if (off >= 16'h0080 || off[0]) return 8'hFF;
    k = int'(off >> 2);
    raw = 8'h00;
    if (k == 0)  raw = 8'hD1;
    if (k == 1)  raw = prod;
    if (k == 4 || k == 5) raw = 8'h12;
    if (k == 10) raw = 8'h10;
    nib = off[1] ? raw[3:0] : raw[7:4];
    if (k != 0) nib = ~nib;
    return {nib, 4'h0};
  endfunction

  task automatic access(input logic we, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    last_hit = card_hit; last_off = local_off;
    @(posedge clk);
    #1;
    last_rd = bus_rdata; last_xrd = x_rdata;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 cfg_done", cfg_done, 0);
    chk("R1 shut_up", shut_up, 0);
    chk("R1 cfg_out", cfg_out, 0);
    chk("R1 base", base_addr, 8'h00);
    chk("R1 rdata", bus_rdata, 8'hFF);
  endtask

  task automatic t_window();
    access(1'b0, 24'hE8_0800, 8'h00);
    chk("R2 hit window", last_hit, 1);
    chk("R2 offset", last_off, 16'h0800);
    access(1'b0, 24'h12_0000, 8'h00);
    chk("R2 miss elsewhere", last_hit, 0);
    chk("R3 miss reads FF", last_rd, 8'hFF);
  endtask

  task automatic t_id();
    for (int o = 0; o < 128; o += 2) begin
      access(1'b0, 24'hE8_0000 | 24'(o), 8'h00);
      chk("R4 id nibble", last_rd, want_rd(16'(o), 8'd0));
      chk("R11 ext id nibble", last_xrd, want_rd(16'(o), 8'd42));
    end
    access(1'b0, 24'hE8_0001, 8'h00);
    chk("R3 odd offset", last_rd, 8'hFF);
    access(1'b0, 24'hE8_0100, 8'h00);
    chk("R3 beyond id space", last_rd, 8'hFF);
    chk("R3 idle FF", bus_rdata, 8'hFF);
    access(1'b0, 24'hE8_0004, 8'h00);
    chk("R11 base product hi", last_rd, 8'hF0);
    chk("R11 ext product hi", last_xrd, 8'hD0);
  endtask

  task automatic t_commit_fresh();
    do_reset();
    access(1'b1, 24'hE8_0048, 8'h30);
    chk("R8 base from zero latch", base_addr, 8'h30);
    chk("R6 cfg_done", cfg_done, 1);
    chk("R6 cfg_out", cfg_out, 1);
    access(1'b0, 24'h30_0000, 8'h00);
    chk("R7 hit at base", last_hit, 1);
    chk("R7 id at base", last_rd, 8'hD0);
    access(1'b0, 24'hE8_0000, 8'h00);
    chk("R7 window gone", last_hit, 0);
  endtask

  task automatic t_locked();
    access(1'b1, 24'h30_004A, 8'hF0);
    access(1'b1, 24'h30_0048, 8'h90);
    chk("R9 base kept", base_addr, 8'h30);
    access(1'b1, 24'h30_004C, 8'h00);
    chk("R9 no shut", shut_up, 0);
    chk("R9 still done", cfg_done, 1);
  endtask

  task automatic t_latch();
    do_reset();
    access(1'b1, 24'hE8_004A, 8'h50);
    access(1'b1, 24'hE8_004A, 8'h70);
    chk("R5 not moved", cfg_done, 0);
    chk("R5 base untouched", base_addr, 8'h00);
    access(1'b0, 24'hE8_0000, 8'h00);
    chk("R5 still at window", last_hit, 1);
    access(1'b1, 24'hE8_0048, 8'h20);
    chk("R5 last nibble wins", base_addr, 8'h27);
    chk("R6 done", cfg_done, 1);
    access(1'b0, 24'h27_1234, 8'h00);
    chk("R7 hit new base", last_hit, 1);
    chk("R7 offset", last_off, 16'h1234);
  endtask

  task automatic t_sleep();
    do_reset();
    access(1'b1, 24'hE8_004A, 8'h40);
    access(1'b1, 24'hE8_004C, 8'h00);
    chk("R10 shut_up", shut_up, 1);
    chk("R10 cfg_out", cfg_out, 1);
    access(1'b0, 24'hE8_0000, 8'h00);
    chk("R10 no hit", last_hit, 0);
    chk("R10 rdata FF", last_rd, 8'hFF);
    access(1'b1, 24'hE8_0048, 8'h80);
    chk("R10 commit ignored", cfg_done, 0);
    chk("R10 base zero", base_addr, 8'h00);
    do_reset();
    chk("R1 shut cleared", shut_up, 0);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_id();
    t_commit_fresh();
    t_locked();
    t_latch();
    t_sleep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung want finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule